// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

A purely combinational datapath slice for an 8-bit processor core. It performs the single-operand byte operations that sit behind the extended opcode page: four rotates (circular or through the carry, in either direction), a left shift, an arithmetic and a logical right shift, and a nibble exchange. It also performs bit test, bit clear and bit set on a bit chosen by a 3-bit index, plus a short accumulator rotate mode whose zero flag behaves differently.

The decoder drives a 4-bit operation code, the operand byte, the current carry flag and the bit index. In the same cycle the unit returns the result byte, four flag values each paired with an update enable, and a write enable that says whether the result goes back to its source. Operand fetch, write-back and instruction decode belong to the neighbouring logic.

Top module: `rsu_top`

## Requirements
- R1: Code 0 (circular left) gives {v[6:0],v[7]} with C=v[7]; code 1 (circular right) gives {v[0],v[7:1]} with C=v[0].
- R2: Code 2 (left through carry) gives {v[6:0],carry_i} with C=v[7]; code 3 (right through carry) gives {carry_i,v[7:1]} with C=v[0].
- R3: Code 4 (left shift) gives {v[6:0],0} with C=v[7]; code 5 (arithmetic right) gives {v[7],v[7:1]} with C=v[0]; code 7 (logical right) gives {0,v[7:1]} with C=v[0].
- R4: For codes 0 to 7 the unit sets Z when the result is zero, drives N=0 and H=0, raises all four update enables and raises the write enable.
- R5: Codes 11, 12, 13 and 14 (accumulator forms) produce the same result and C as codes 0, 1, 2 and 3 respectively, but drive Z=0 for every operand, with all four enables and the write enable high.
- R6: Code 6 (nibble exchange) gives {v[3:0],v[7:4]}, sets Z from the result and drives N=H=C=0.
- R7: Code 8 (bit test) sets Z when bit idx_i of the operand is 0, drives N=0 and H=1, leaves the C enable low, keeps the write enable low and returns the operand unchanged.
- R8: Codes 9 (clear) and 10 (set) force bit idx_i (index 0 is the least significant bit) to 0 or 1, leave every other bit, raise the write enable and keep all four flag enables low.
- R9: Code 15 (idle) returns the operand, keeps the write enable and every flag enable low.
- R10: A flag output whose update enable is low is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_i | input | 8 | Operand byte |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code (see requirements) |
| idx_i | input | 3 | Bit index for test, clear and set |
| res_o | output | 8 | Result byte |
| flag_z_o | output | 1 | Zero flag value |
| flag_n_o | output | 1 | Subtract flag value |
| flag_h_o | output | 1 | Half-carry flag value |
| flag_c_o | output | 1 | Carry flag value |
| upd_z_o | output | 1 | Update enable for Z |
| upd_n_o | output | 1 | Update enable for N |
| upd_h_o | output | 1 | Update enable for H |
| upd_c_o | output | 1 | Update enable for C |
| wr_en_o | output | 1 | Result write-back enable |

## Verification
The bench walks every operation over all operand bytes, both carry inputs and all eight indices, so a swapped fill bit (circular versus through-carry) shows up as a wrong bit 0 or bit 7 on half the operands. Zero-result cases such as a lone bit rotated out are targeted because a unit that forgets to force Z low in the accumulator forms would report Z=1 there, while one that forces it in the prefixed forms would miss the zero. Bit test on index 7 and clear on index 0 guard against an off-by-one or reversed index decode, and the test must show a low write enable and C enable, since a leaky bit test would corrupt the register or the carry.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  typedef enum logic [3:0] {
    OP_RLC  = 4'd0,
    OP_RRC  = 4'd1,
    OP_RL   = 4'd2,
    OP_RR   = 4'd3,
    OP_SLA  = 4'd4,
    OP_SRA  = 4'd5,
    OP_SWAP = 4'd6,
    OP_SRL  = 4'd7,
    OP_BTST = 4'd8,
    OP_BCLR = 4'd9,
    OP_BSET = 4'd10,
    OP_ARLC = 4'd11,
    OP_ARRC = 4'd12,
    OP_ARL  = 4'd13,
    OP_ARR  = 4'd14,
    OP_IDLE = 4'd15
  } rsu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } rsu_flags_t;

  // accumulator-only rotate forms
  function automatic logic is_acc_rot(input rsu_op_e op);
    return (op == OP_ARLC) || (op == OP_ARRC) || (op == OP_ARL) || (op == OP_ARR);
  endfunction

  // prefixed shift/rotate/swap page
  function automatic logic is_prefixed_shift(input rsu_op_e op);
    return op <= OP_SRL;
  endfunction

  // map an accumulator rotate onto its prefixed data path
  function automatic rsu_op_e to_prefixed(input rsu_op_e op);
    rsu_op_e m;
    case (op)
      OP_ARLC: m = OP_RLC;
      OP_ARRC: m = OP_RRC;
      OP_ARL:  m = OP_RL;
      OP_ARR:  m = OP_RR;
      default: m = op;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rsu_shift_path.sv
module rsu_shift_path
  import rsu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opd_i,
  input  logic              carry_i,
  input  rsu_op_e           sel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);

  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] move_up(input logic [DATA_W-1:0] v, input logic fill);
    return {v[DATA_W-2:0], fill};
  endfunction

  function automatic logic [DATA_W-1:0] move_down(input logic [DATA_W-1:0] v, input logic fill);
    return {fill, v[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] swap_halves(input logic [DATA_W-1:0] v);
    return {v[HALF_W-1:0], v[DATA_W-1:HALF_W]};
  endfunction

  logic top_bit;
  logic low_bit;

  assign top_bit = opd_i[DATA_W-1];
  assign low_bit = opd_i[0];

  always_comb begin
    res_o   = opd_i;
    carry_o = 1'b0;
    case (sel_i)
      OP_RLC:  begin res_o = move_up(opd_i, top_bit);     carry_o = top_bit; end
      OP_RL:   begin res_o = move_up(opd_i, carry_i);     carry_o = top_bit; end
      OP_SLA:  begin res_o = move_up(opd_i, 1'b0);        carry_o = top_bit; end
      OP_RRC:  begin res_o = move_down(opd_i, low_bit);   carry_o = low_bit; end
      OP_RR:   begin res_o = move_down(opd_i, carry_i);   carry_o = low_bit; end
      OP_SRA:  begin res_o = move_down(opd_i, top_bit);   carry_o = low_bit; end
      OP_SRL:  begin res_o = move_down(opd_i, 1'b0);      carry_o = low_bit; end
      OP_SWAP: begin res_o = swap_halves(opd_i);          carry_o = 1'b0;    end
      default: begin res_o = opd_i;                       carry_o = 1'b0;    end
    endcase
  end

  // carry out of any moving operation is one of the operand's edge bits
  always_comb begin
    if ((sel_i <= OP_SRL) && (sel_i != OP_SWAP)) begin
      assert_cout_edge_R1: assert (carry_o == top_bit || carry_o == low_bit)
        else $error("carry out is not an edge bit");
    end
    if (sel_i == OP_SWAP) begin
      assert_swap_ones_R6: assert ($countones(res_o) == $countones(opd_i))
        else $error("nibble exchange changed the bit count");
    end
  end

endmodule

// File: rtl/rsu_bit_path.sv
module rsu_bit_path #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opd_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_zero_o,
  output logic [DATA_W-1:0] cleared_o,
  output logic [DATA_W-1:0] setbit_o
);

  logic [DATA_W-1:0] sel_mask;

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign sel_mask[b] = (idx_i == IDX_W'(b));
  end

  assign bit_zero_o = ~|(opd_i & sel_mask);
  assign cleared_o  = opd_i & ~sel_mask;
  assign setbit_o   = opd_i | sel_mask;

  always_comb begin
    assert_one_hot_R8: assert ($onehot0(sel_mask) && (sel_mask != '0))
      else $error("bit select is not one-hot");
    assert_clr_low_R8: assert (cleared_o[idx_i] == 1'b0)
      else $error("cleared bit still set");
    assert_set_high_R8: assert (setbit_o[idx_i] == 1'b1)
      else $error("set bit still clear");
    assert_pair_diff_R8: assert ($countones(cleared_o ^ setbit_o) == 1)
      else $error("clear and set differ in more than the chosen bit");
  end

endmodule

// File: rtl/rsu_top.sv
module rsu_top
  import rsu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opd_i,
  input  logic              carry_i,
  input  logic [3:0]        op_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] res_o,
  output logic              flag_z_o,
  output logic              flag_n_o,
  output logic              flag_h_o,
  output logic              flag_c_o,
  output logic              upd_z_o,
  output logic              upd_n_o,
  output logic              upd_h_o,
  output logic              upd_c_o,
  output logic              wr_en_o
);

  rsu_op_e           op;
  rsu_op_e           path_sel;
  logic              acc_form;
  logic              shift_form;
  logic [DATA_W-1:0] sh_res;
  logic              sh_carry;
  logic              tst_zero;
  logic [DATA_W-1:0] clr_res;
  logic [DATA_W-1:0] set_res;
  rsu_flags_t        flg;
  rsu_flags_t        upd;

  assign op         = rsu_op_e'(op_i);
  assign acc_form   = is_acc_rot(op);
  assign shift_form = is_prefixed_shift(op) || acc_form;
  assign path_sel   = to_prefixed(op);

  rsu_shift_path #(.DATA_W(DATA_W)) shift_i (
    .opd_i   (opd_i),
    .carry_i (carry_i),
    .sel_i   (path_sel),
    .res_o   (sh_res),
    .carry_o (sh_carry)
  );

  rsu_bit_path #(.DATA_W(DATA_W)) bits_i (
    .opd_i      (opd_i),
    .idx_i      (idx_i),
    .bit_zero_o (tst_zero),
    .cleared_o  (clr_res),
    .setbit_o   (set_res)
  );

  always_comb begin
    res_o   = opd_i;
    flg     = '0;
    upd     = '0;
    wr_en_o = 1'b0;
    if (shift_form) begin
      res_o   = sh_res;
      flg.z   = acc_form ? 1'b0 : (sh_res == '0);
      flg.c   = sh_carry;
      upd     = '1;
      wr_en_o = 1'b1;
    end else begin
      case (op)
        OP_BTST: begin
          flg.z = tst_zero;
          flg.h = 1'b1;
          upd   = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b0};
        end
        OP_BCLR: begin res_o = clr_res; wr_en_o = 1'b1; end
        OP_BSET: begin res_o = set_res; wr_en_o = 1'b1; end
        default: ;
      endcase
    end
  end

  assign flag_z_o = flg.z;
  assign flag_n_o = flg.n;
  assign flag_h_o = flg.h;
  assign flag_c_o = flg.c;
  assign upd_z_o  = upd.z;
  assign upd_n_o  = upd.n;
  assign upd_h_o  = upd.h;
  assign upd_c_o  = upd.c;

  always_comb begin
    if (shift_form) begin
      assert_nh_clear_R4: assert (!flag_n_o && !flag_h_o && upd_z_o && upd_c_o && wr_en_o)
        else $error("shift group flag or enable mismatch");
    end
    if (acc_form) begin
      assert_acc_zclear_R5: assert (!flag_z_o)
        else $error("accumulator rotate reported Z");
    end
    if (op == OP_BTST) begin
      assert_btst_quiet_R7: assert (!wr_en_o && !upd_c_o && flag_h_o && res_o == opd_i)
        else $error("bit test wrote or touched carry");
    end
    if (op == OP_BCLR || op == OP_BSET) begin
      assert_bitop_noflag_R8: assert (!upd_z_o && !upd_n_o && !upd_h_o && !upd_c_o)
        else $error("bit clear/set raised a flag enable");
    end
    if (op == OP_IDLE) begin
      assert_idle_quiet_R9: assert (!wr_en_o && !upd_z_o && !upd_c_o && res_o == opd_i)
        else $error("idle code had an effect");
    end
    assert_gated_flags_R10: assert ((upd_c_o || !flag_c_o) && (upd_z_o || !flag_z_o)
                                    && (upd_h_o || !flag_h_o))
      else $error("flag driven while its enable is low");
  end

endmodule

// File: tb/rsu_top_tb_top.sv
module rsu_top_tb_top;

  logic       clk = 1'b0;
  logic [7:0] opd;
  logic       cin;
  logic [3:0] op;
  logic [2:0] idx;
  logic [7:0] res;
  logic       fz, fn, fh, fc, uz, un, uh, uc, wr;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rsu_top dut_i (
    .opd_i(opd), .carry_i(cin), .op_i(op), .idx_i(idx),
    .res_o(res),
    .flag_z_o(fz), .flag_n_o(fn), .flag_h_o(fh), .flag_c_o(fc),
    .upd_z_o(uz), .upd_n_o(un), .upd_h_o(uh), .upd_c_o(uc),
    .wr_en_o(wr)
  );

  // {req, op, operand, carry, idx, result, flags ZNHC, enables ZNHC, write}
  localparam int NVEC = 15;
  localparam logic [36:0] VECS [NVEC] = '{
    {4'd1, 4'd0,  8'h85, 1'b0, 3'd0, 8'h0B, 4'b0001, 4'b1111, 1'b1}, // R1 circular left
    {4'd1, 4'd1,  8'h02, 1'b1, 3'd0, 8'h01, 4'b0000, 4'b1111, 1'b1}, // R1 circular right
    {4'd2, 4'd3,  8'h01, 1'b0, 3'd0, 8'h00, 4'b1001, 4'b1111, 1'b1}, // R2 R4 zero result
    {4'd2, 4'd2,  8'h80, 1'b1, 3'd0, 8'h01, 4'b0001, 4'b1111, 1'b1}, // R2 carry in to bit 0
    {4'd3, 4'd5,  8'h81, 1'b0, 3'd0, 8'hC0, 4'b0001, 4'b1111, 1'b1}, // R3 sign kept
    {4'd3, 4'd7,  8'h01, 1'b1, 3'd0, 8'h00, 4'b1001, 4'b1111, 1'b1}, // R3 R4 logical right
    {4'd3, 4'd4,  8'hFF, 1'b0, 3'd0, 8'hFE, 4'b0001, 4'b1111, 1'b1}, // R3 left shift
    {4'd6, 4'd6,  8'hF0, 1'b1, 3'd0, 8'h0F, 4'b0000, 4'b1111, 1'b1}, // R6 swap clears C
    {4'd6, 4'd6,  8'h00, 1'b0, 3'd0, 8'h00, 4'b1000, 4'b1111, 1'b1}, // R6 swap zero
    {4'd5, 4'd12, 8'h01, 1'b0, 3'd0, 8'h80, 4'b0001, 4'b1111, 1'b1}, // R5 acc circular right
    {4'd5, 4'd13, 8'h80, 1'b0, 3'd0, 8'h00, 4'b0001, 4'b1111, 1'b1}, // R5 zero result, Z low
    {4'd7, 4'd8,  8'h7F, 1'b1, 3'd7, 8'h7F, 4'b1010, 4'b1110, 1'b0}, // R7 R10 test bit 7
    {4'd8, 4'd9,  8'hFF, 1'b1, 3'd0, 8'hFE, 4'b0000, 4'b0000, 1'b1}, // R8 clear bit 0
    {4'd8, 4'd10, 8'h00, 1'b1, 3'd3, 8'h08, 4'b0000, 4'b0000, 1'b1}, // R8 set bit 3
    {4'd9, 4'd15, 8'h5A, 1'b1, 3'd5, 8'h5A, 4'b0000, 4'b0000, 1'b0}  // R9 idle
  };

  task automatic apply(input int o, input int v, input int c, input int ix);
    op  = 4'(o);
    opd = 8'(v);
    cin = 1'(c);
    idx = 3'(ix);
    #1;
  endtask

  task automatic compare(input int req, input int er, input int ef, input int ee, input int ew);
    int af, ae;
    af = {fz, fn, fh, fc};
    ae = {uz, un, uh, uc};
    n_checks++;
    if (res !== 8'(er) || af != ef || ae != ee || wr !== 1'(ew)) begin
      n_fails++;
      $display("FAIL R%0d op=%0d opd=%02h c=%0d idx=%0d: got res=%02h f=%04b e=%04b w=%0d, expected res=%02h f=%04b e=%04b w=%0d",
               req, op, opd, cin, idx, res, af[3:0], ae[3:0], wr, er, ef[3:0], ee[3:0], ew);
    end
  endtask

  // independent arithmetic model of the requirements
  task automatic model(input int o, input int v, input int c, input int ix,
                       output int r, output int f, output int e, output int w, output int req);
    int b7, b0, z, h, cf, tb;
    b7 = v / 128; b0 = v % 2; z = 0; h = 0; cf = 0;
    r = v; e = 15; w = 1; req = 9;
    tb = (v / (1 << ix)) % 2;
    case (o)
      0, 11: begin r = (v * 2) % 256 + b7;   cf = b7; req = 1; end  // R1
      1, 12: begin r = v / 2 + b0 * 128;     cf = b0; req = 1; end  // R1
      2, 13: begin r = (v * 2) % 256 + c;    cf = b7; req = 2; end  // R2
      3, 14: begin r = v / 2 + c * 128;      cf = b0; req = 2; end  // R2
      4:     begin r = (v * 2) % 256;        cf = b7; req = 3; end  // R3
      5:     begin r = v / 2 + b7 * 128;     cf = b0; req = 3; end  // R3
      7:     begin r = v / 2;                cf = b0; req = 3; end  // R3
      6:     begin r = (v % 16) * 16 + v / 16; cf = 0; req = 6; end // R6
      8:     begin z = (tb == 0); h = 1; e = 14; w = 0; req = 7; end // R7
      9:     begin r = v - tb * (1 << ix); e = 0; req = 8; end      // R8
      10:    begin r = v + (1 - tb) * (1 << ix); e = 0; req = 8; end
      default: begin e = 0; w = 0; req = 9; end                     // R9
    endcase
    if (o <= 7) z = (r == 0);                 // R4
    if (o >= 11 && o <= 14) begin z = 0; req = 5; end  // R5
    f = z * 8 + h * 2 + cf;                   // N always 0; gated flags 0 per R10
  endtask

  initial begin
    int r, f, e, w, req;
    // quiet state at start: idle code, no write, no flags (R9)
    apply(15, 8'hA5, 0, 0);
    compare(9, 8'hA5, 0, 0, 0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i][32:29], VECS[i][28:21], VECS[i][20], VECS[i][19:17]);
      compare(VECS[i][36:33], VECS[i][16:9], VECS[i][8:5], VECS[i][4:1], VECS[i][0]);
    end

    // exhaustive sweep: all codes, operands, carries, indices
    for (int o = 0; o < 16; o++)
      for (int v = 0; v < 256; v++)
        for (int c = 0; c < 2; c++)
          for (int ix = 0; ix < 8; ix++) begin
            apply(o, v, c, ix);
            model(o, v, c, ix, r, f, e, w, req);
            compare(req, r, f, e, w);
          end

    // directed corners: test bit 0 set (R7), set of an already set bit (R8)
    apply(8, 8'h01, 0, 0);  compare(7, 8'h01, 4'b0010, 4'b1110, 0);
    apply(10, 8'h80, 0, 7); compare(8, 8'h80, 0, 0, 1);
    apply(9, 8'h00, 1, 7);  compare(8, 8'h00, 0, 0, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule